// File: doc/BRIEF.md
# Wide-Word Sixteen-Operation Execute Unit

This block is the execute stage for one issue slot of a three-slot long-instruction-word core. Each cycle it may accept one operation: a 4-bit opcode, two source words A and B, and a short immediate. It returns a result word, an equal flag, an unsigned less-than flag, and a write-enable that tells the writeback stage whether a register should be written. Three identical copies run side by side in the same cycle, one per instruction slot. Fetch, decode, the register file and operand forwarding are not part of this block.

The word width is a parameter, legal from 64 to 256 in steps of 32. The operation set covers wrapping add and subtract, a low-half multiply written as plain RTL, immediate load, A and B pass-through, an unsigned compare, xor, nand, nor, not, single-bit logical shifts and barrel rotations. One register stage sits on the output.

Both edges use valid/ready. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. A result is consumed on a rising edge where `out_valid` and `out_ready` are both high. While a result is waiting and the consumer holds `out_ready` low, the unit accepts nothing and holds every output. The upstream side has to keep its operation steady until it is accepted.

Top module: `wide_exec_unit`

## Requirements
- R1: When `rst_n` is low, `out_valid`, `out_wr_en`, `out_eq`, `out_lt` and `out_result` are all 0.
- R2: Opcode 4'h1 returns (A+B) mod 2^WIDTH and opcode 4'h2 returns (A−B) mod 2^WIDTH, both with `out_wr_en`=1.
- R3: Opcode 4'h3 returns the low WIDTH bits of the unsigned product A*B.
- R4: Opcode 4'h4 returns the immediate, zero-extended. Opcode 4'h5 returns A and opcode 4'h6 returns B.
- R5: Opcode 4'h7 (compare) sets `out_eq` when A equals B and `out_lt` when A is below B as unsigned numbers. It returns a result of 0 with `out_wr_en`=0.
- R6: Opcode 4'h8 returns A xor B, 4'h9 returns ~(A&B), 4'hA returns ~(A|B), and 4'hB returns ~A.
- R7: Opcode 4'hC shifts A left by one bit and 4'hD shifts A right by one bit. Both fill the vacated bit with 0.
- R8: Opcode 4'hE rotates A left and 4'hF rotates A right. The rotate amount is the low ceil(log2(WIDTH)) bits of B, taken modulo WIDTH.
- R9: Opcode 4'h0 (nop) still produces a result beat, with `out_result`=0 and `out_wr_en`=0.
- R10: An operation accepted on a rising edge shows up on the outputs right after that edge, with `out_valid`=1.
- R11: `in_ready` is low only while a result is waiting and `out_ready` is low. During that time `out_result`, the flags and `out_wr_en` stay unchanged.
- R12: When a result is consumed and no new operation is accepted on the same edge, `out_valid` falls.
- R13: Every opcode other than compare returns `out_eq`=0 and `out_lt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can take an operation this cycle |
| in_op | input | 4 | Opcode |
| in_a | input | WIDTH | Source operand A |
| in_b | input | WIDTH | Source operand B, which also carries the rotate amount |
| in_imm | input | IMM_W | Immediate for the load operation |
| out_valid | output | 1 | A result beat is present |
| out_ready | input | 1 | The consumer takes the result beat |
| out_result | output | WIDTH | Result word |
| out_wr_en | output | 1 | Writeback should write the result |
| out_eq | output | 1 | Compare: A equals B |
| out_lt | output | 1 | Compare: A below B, unsigned |

## Verification
The bench builds two copies of the unit at once, one at WIDTH=64 and one at WIDTH=96, both fed the same stimulus. The 64-bit copy is the smallest legal width. At that size every opcode can be swept against corner operands and a spread of mixed values, and every rotate amount from 0 to 63 can be tried. The 96-bit copy is a width that is not a power of two. There the 7-bit rotate field can exceed the word width, so sweeping all 128 amounts exercises the modulo wrap of R8. The bench then runs a stall-and-drain sequence to cover the handshake rules.

// File: rtl/wx_pkg.sv
package wx_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'h0, OP_ADD  = 4'h1, OP_SUB  = 4'h2, OP_MUL  = 4'h3,
    OP_LDI  = 4'h4, OP_MOVA = 4'h5, OP_MOVB = 4'h6, OP_CMP  = 4'h7,
    OP_XOR  = 4'h8, OP_NAND = 4'h9, OP_NOR  = 4'hA, OP_NOT  = 4'hB,
    OP_SHL1 = 4'hC, OP_SHR1 = 4'hD, OP_ROTL = 4'hE, OP_ROTR = 4'hF
  } wx_op_e;
endpackage

// File: rtl/wx_arith.sv
module wx_arith #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic [WIDTH-1:0] diff,
  output logic [WIDTH-1:0] prod,
  output logic             eq,
  output logic             lt
);
  always_comb begin
    sum  = a + b;
    diff = a - b;
    prod = a * b;
    eq   = (a == b);
    lt   = (a < b);
  end
endmodule

// File: rtl/wx_logic.sv
module wx_logic #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] x_xor,
  output logic [WIDTH-1:0] x_nand,
  output logic [WIDTH-1:0] x_nor,
  output logic [WIDTH-1:0] x_not
);
  always_comb begin
    x_xor  = a ^ b;
    x_nand = ~(a & b);
    x_nor  = ~(a | b);
    x_not  = ~a;
  end
endmodule

// File: rtl/wx_shift.sv
module wx_shift #(
  parameter int WIDTH = 64,
  localparam int SH_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a,
  input  logic [SH_W-1:0]  amt,
  output logic [WIDTH-1:0] shl1,
  output logic [WIDTH-1:0] shr1,
  output logic [WIDTH-1:0] rotl,
  output logic [WIDTH-1:0] rotr
);
  localparam logic [SH_W:0] WIDTH_V = (SH_W+1)'(WIDTH);

  logic [SH_W:0]      amt_red;
  logic [2*WIDTH-1:0] dbl_l;
  logic [2*WIDTH-1:0] dbl_r;

  always_comb begin
    amt_red = {1'b0, amt} % WIDTH_V;
    shl1    = {a[WIDTH-2:0], 1'b0};
    shr1    = {1'b0, a[WIDTH-1:1]};
    dbl_l   = {a, a} << amt_red;
    dbl_r   = {a, a} >> amt_red;
    rotl    = dbl_l[2*WIDTH-1:WIDTH];
    rotr    = dbl_r[WIDTH-1:0];
  end
endmodule

// File: rtl/wide_exec_unit.sv
module wide_exec_unit
  import wx_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int IMM_W = 16,
  localparam int SH_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_op,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic [IMM_W-1:0] in_imm,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_result,
  output logic             out_wr_en,
  output logic             out_eq,
  output logic             out_lt
);
  if ((WIDTH % 32) != 0 || WIDTH < 64 || WIDTH > 256 || IMM_W > WIDTH) begin : g_bad_cfg
    $error("wide_exec_unit: illegal WIDTH/IMM_W");
  end

  logic [WIDTH-1:0] r_sum, r_diff, r_prod;
  logic [WIDTH-1:0] l_xor, l_nand, l_nor, l_not;
  logic [WIDTH-1:0] s_shl, s_shr, s_rotl, s_rotr;
  logic             c_eq, c_lt;

  wx_arith #(.WIDTH(WIDTH)) u_arith (
    .a(in_a), .b(in_b), .sum(r_sum), .diff(r_diff), .prod(r_prod),
    .eq(c_eq), .lt(c_lt)
  );

  wx_logic #(.WIDTH(WIDTH)) u_logic (
    .a(in_a), .b(in_b), .x_xor(l_xor), .x_nand(l_nand), .x_nor(l_nor),
    .x_not(l_not)
  );

  wx_shift #(.WIDTH(WIDTH)) u_shift (
    .a(in_a), .amt(in_b[SH_W-1:0]), .shl1(s_shl), .shr1(s_shr),
    .rotl(s_rotl), .rotr(s_rotr)
  );

  logic [WIDTH-1:0] nx_result;
  logic             nx_wr_en, nx_eq, nx_lt;

  always_comb begin
    nx_result = '0;
    nx_wr_en  = 1'b1;
    nx_eq     = 1'b0;
    nx_lt     = 1'b0;
    unique case (wx_op_e'(in_op))
      OP_NOP:  nx_wr_en = 1'b0;
      OP_ADD:  nx_result = r_sum;
      OP_SUB:  nx_result = r_diff;
      OP_MUL:  nx_result = r_prod;
      OP_LDI:  nx_result = WIDTH'(in_imm);
      OP_MOVA: nx_result = in_a;
      OP_MOVB: nx_result = in_b;
      OP_CMP: begin
        nx_wr_en = 1'b0;
        nx_eq    = c_eq;
        nx_lt    = c_lt;
      end
      OP_XOR:  nx_result = l_xor;
      OP_NAND: nx_result = l_nand;
      OP_NOR:  nx_result = l_nor;
      OP_NOT:  nx_result = l_not;
      OP_SHL1: nx_result = s_shl;
      OP_SHR1: nx_result = s_shr;
      OP_ROTL: nx_result = s_rotl;
      OP_ROTR: nx_result = s_rotr;
      default: nx_wr_en = 1'b0;
    endcase
  end

  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wr_en  <= 1'b0;
      out_eq     <= 1'b0;
      out_lt     <= 1'b0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_result <= nx_result;
      out_wr_en  <= nx_wr_en;
      out_eq     <= nx_eq;
      out_lt     <= nx_lt;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/wx_checker.sv
module wx_checker #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [3:0]       in_op,
  input logic [WIDTH-1:0] in_a,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_result,
  input logic             out_wr_en,
  input logic             out_eq,
  input logic             out_lt
);
  assert_stall_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_wr_en)
                                   && $stable(out_eq) && $stable(out_lt)));

  assert_stall_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_drain_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  assert_accept_shows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 4'h7) |=> (out_valid && !out_wr_en && out_result == '0));

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_eq |-> !out_lt);

  assert_flags_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_en |-> (!out_eq && !out_lt));

  assert_move_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 4'h5) |=> (out_result == $past(in_a)));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !out_wr_en));
endmodule

bind wide_exec_unit wx_checker #(.WIDTH(WIDTH)) u_wx_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_a(in_a), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_wr_en(out_wr_en), .out_eq(out_eq), .out_lt(out_lt)
);

// File: tb/test_wide_exec_unit.sv
`timescale 1ns/1ps
module test_wide_exec_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [3:0]  in_op = 4'h0;
  logic [95:0] in_a = '0;
  logic [95:0] in_b = '0;
  logic [15:0] in_imm = '0;

  logic        rdy64, ov64, we64, eq64, lt64;
  logic [63:0] res64;
  logic        rdy96, ov96, we96, eq96, lt96;
  logic [95:0] res96;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wide_exec_unit #(.WIDTH(64), .IMM_W(16)) i_wide_exec_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy64),
    .in_op(in_op), .in_a(in_a[63:0]), .in_b(in_b[63:0]), .in_imm(in_imm),
    .out_valid(ov64), .out_ready(out_ready), .out_result(res64),
    .out_wr_en(we64), .out_eq(eq64), .out_lt(lt64)
  );

  wide_exec_unit #(.WIDTH(96), .IMM_W(16)) i_wide_exec_unit_w96 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy96),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
    .out_valid(ov96), .out_ready(out_ready), .out_result(res96),
    .out_wr_en(we96), .out_eq(eq96), .out_lt(lt96)
  );

  task automatic check(string req, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'h0: return "R9";
      4'h1, 4'h2: return "R2";
      4'h3: return "R3";
      4'h4, 4'h5, 4'h6: return "R4";
      4'h7: return "R5";
      4'h8, 4'h9, 4'hA, 4'hB: return "R6";
      4'hC, 4'hD: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [95:0] model(int w, logic [3:0] op, logic [95:0] a0,
                                        logic [95:0] b0, logic [15:0] imm);
    logic [95:0]  m, a, b, r;
    logic [191:0] p;
    int amt;
    m = (w == 96) ? {96{1'b1}} : {32'h0, {64{1'b1}}};
    a = a0 & m;
    b = b0 & m;
    r = '0;
    case (op)
      4'h1: r = a + b;
      4'h2: r = a - b;
      4'h3: begin p = a * b; r = p[95:0]; end
      4'h4: r = {80'h0, imm};
      4'h5: r = a;
      4'h6: r = b;
      4'h8: r = a ^ b;
      4'h9: r = ~(a & b);
      4'hA: r = ~(a | b);
      4'hB: r = ~a;
      4'hC: r = a << 1;
      4'hD: r = a >> 1;
      4'hE, 4'hF: begin
        amt = (w == 96) ? (int'(b[6:0]) % 96) : int'(b[5:0]);
        for (int i = 0; i < w; i++) begin
          if (op == 4'hE) r[(i + amt) % w] = a[i];
          else            r[i] = a[(i + amt) % w];
        end
      end
      default: r = '0;
    endcase
    return r & m;
  endfunction

  task automatic run_op(logic [3:0] op, logic [95:0] a, logic [95:0] b, logic [15:0] imm);
    string rq;
    logic cmp;
    rq = req_of(op);
    cmp = (op == 4'h7);
    in_op = op; in_a = a; in_b = b; in_imm = imm;
    in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({rq, " R10 valid64"}, {95'h0, ov64}, 96'h1);
    check({rq, " R10 valid96"}, {95'h0, ov96}, 96'h1);
    check({rq, " result64"}, {32'h0, res64}, model(64, op, a, b, imm));
    check({rq, " result96"}, res96, model(96, op, a, b, imm));
    check({rq, " wr_en64"}, {95'h0, we64}, {95'h0, !(op == 4'h0 || cmp)});
    check({rq, " wr_en96"}, {95'h0, we96}, {95'h0, !(op == 4'h0 || cmp)});
    check(cmp ? "R5 eq64" : "R13 eq64", {95'h0, eq64}, {95'h0, cmp && (a[63:0] == b[63:0])});
    check(cmp ? "R5 lt64" : "R13 lt64", {95'h0, lt64}, {95'h0, cmp && (a[63:0] < b[63:0])});
    check(cmp ? "R5 eq96" : "R13 eq96", {95'h0, eq96}, {95'h0, cmp && (a == b)});
    check(cmp ? "R5 lt96" : "R13 lt96", {95'h0, lt96}, {95'h0, cmp && (a < b)});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [95:0] pats [0:7];
    logic [95:0] x;
    pats[0] = '0;
    pats[1] = {96{1'b1}};
    pats[2] = 96'h1;
    pats[3] = {1'b1, 95'h0};
    pats[4] = {32'h0, 1'b1, 63'h0};
    pats[5] = 96'h5555_5555_5555_5555_5555_5555;
    pats[6] = 96'hdead_beef_0123_4567_89ab_cdef;
    pats[7] = 96'h0000_0001_ffff_ffff_ffff_ffff;

    repeat (3) @(negedge clk);
    // R1: outputs quiet while reset is held
    check("R1 valid", {94'h0, ov64, ov96}, '0);
    check("R1 wr_en", {94'h0, we64, we96}, '0);
    check("R1 flags", {92'h0, eq64, lt64, eq96, lt96}, '0);
    check("R1 result", res96 | {32'h0, res64}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_op(4'(op), pats[i], pats[j], pats[(i + j) % 8][15:0]);

    // R5: equal operands of mixed widths, and R8 full amount sweep incl. wrap above 95
    for (int k = 0; k < 40; k++) begin
      x = {$urandom, $urandom, $urandom};
      run_op(4'h7, x, x, 16'h0);
      run_op(4'h3, x, {$urandom, $urandom, $urandom}, 16'h0);
      run_op(4'h1, x, {$urandom, $urandom, $urandom}, 16'h0);
    end
    for (int s = 0; s < 128; s++) begin
      run_op(4'hE, pats[6], 96'(s), 16'h0);
      run_op(4'hF, pats[6], 96'(s), 16'h0);
    end

    // R12: drain with nothing new
    in_valid = 1'b0; out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R12 valid drops64", {95'h0, ov64}, '0);
    check("R12 valid drops96", {95'h0, ov96}, '0);

    // R11: stall and hold
    in_op = 4'h5; in_a = pats[6]; in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R10 stalled accept", {32'h0, res64}, {32'h0, pats[6][63:0]});
    in_a = pats[5];
    #1;
    check("R11 ready low64", {95'h0, rdy64}, '0);
    check("R11 ready low96", {95'h0, rdy96}, '0);
    @(posedge clk); @(negedge clk);
    check("R11 held result", res96, pats[6]);
    check("R11 held valid", {95'h0, ov96}, 96'h1);
    out_ready = 1'b1;
    #1;
    check("R11 ready back", {95'h0, rdy96}, 96'h1);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check("R11 next accepted", res96, pats[5]);
    @(posedge clk); @(negedge clk);
    check("R12 final drain", {95'h0, ov96}, '0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule